// File: doc/BRIEF.md
# Security-aware interrupt controller

This block collects 109 level-sensitive interrupt request lines and exposes them to a processor through a small memory-mapped register window on a 32-bit bus. Every source has its own enable flag, a security attribute bit and an 8-bit priority. The controller finds the eligible sources that have the highest priority value and above a programmable threshold. It reports them as a bitmap that software can read, and it raises a single interrupt request output while that bitmap is non-empty.

Enable flags are changed through two separate banks, one where written ones set flags and one where written ones clear them, so no read-modify-write is ever needed. Software can also inject a request for any source by writing the source number to a trigger register. That request stays latched until the source is disabled. A global enable and a guarded non-secure-access bit sit in the control register. The guard means a stray write cannot flip the non-secure bit.

Top module: `secirq_ctrl`

## Requirements
- R1: After reset every register reads 0, the highest-pending bitmap is empty and irq_out is 0.
- R2: Control register at offset 0x000: bit 0 is the global enable (read/write). Bit 16 is the non-secure-access bit, and a write changes it only when bit 31 of the same write data is 1. Bit 31 always reads 0.
- R3: The threshold register at offset 0x00C holds an 8-bit threshold in bits 7:0. Its upper bits read 0.
- R4: The security bank at 0x080 holds source i at word i/32, bit i%32, and is read/write. Bits for source numbers 109 and above read 0 and ignore writes.
- R5: Writing the set bank at 0x100 (same bit layout as R4) enables each source whose data bit is 1. Zero bits leave the flags unchanged. Reads return the current enable flags.
- R6: Writing the clear bank at 0x180 (same bit layout) disables each source whose data bit is 1. Zero bits leave the flags unchanged. Reads also return the current enable flags.
- R7: The priority of source i sits in byte i%4 (bits 8*(i%4)+7 : 8*(i%4)) of the word at 0x400 + 4*(i/4). Bytes for sources 109 and above read 0 and ignore writes.
- R8: A source is eligible only when it has a request, its enable flag is set, the global enable is set and its priority is strictly greater than the threshold. A request is either its line being high or its software latch being set.
- R9: The bitmap at 0xD80 (same bit layout as R4, read-only) has a 1 for every eligible source whose priority equals the largest priority among eligible sources, so ties all show.
- R10: irq_out is 1 exactly when the bitmap has a set bit. Both change on the first clock edge after the condition that causes them.
- R11: Writing a value to 0xF00 sets the software latch of the source numbered by bits 9:0 of the data. Numbers of 109 and above are ignored. The latch holds until a 1 is written to that source's bit in the clear bank.
- R12: Read data appears on bus_rdata after the clock edge that samples bus_rd and is held until the next read. Unmapped or misaligned addresses (addr[1:0] not 0) read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 109 | Level request line for each source |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 12 | Byte address in the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The hardest state to reach from the ports is a source that is pending only because of its software latch. Proving that the latch has really been dropped takes a second step: after the clear-bank write, the source must be enabled again and the bitmap must still be empty. The bench therefore triggers the top source (number 108, in the partly filled last word), disables it, enables it again and reads the bitmap. It then writes the out-of-range numbers 109 and 1023 to the trigger register and checks that nothing appears. Ties and the strict threshold are reached by giving two active lines equal priorities and moving the threshold to just at and just below that value.

// File: rtl/secirq_pkg.sv
package secirq_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int PRIO_W = 8;
  localparam int ID_W   = 10;

  localparam logic [ADDR_W-1:0] OFF_CTRL   = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_THRESH = 12'h00C;
  localparam logic [ADDR_W-1:0] BASE_SEC   = 12'h080;
  localparam logic [ADDR_W-1:0] BASE_ENSET = 12'h100;
  localparam logic [ADDR_W-1:0] BASE_ENCLR = 12'h180;
  localparam logic [ADDR_W-1:0] BASE_PRIO  = 12'h400;
  localparam logic [ADDR_W-1:0] BASE_HIP   = 12'hD80;
  localparam logic [ADDR_W-1:0] OFF_TRIG   = 12'hF00;
endpackage

// File: rtl/secirq_regs.sv
module secirq_regs
  import secirq_pkg::*;
#(
  parameter int NUM_SRC = 109
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [DATA_W-1:0]         bus_wdata,
  output logic [DATA_W-1:0]         bus_rdata,
  input  logic [NUM_SRC-1:0]        hip_vec,
  output logic [NUM_SRC-1:0]        en_vec,
  output logic [NUM_SRC-1:0]        sw_vec,
  output logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  output logic [PRIO_W-1:0]         thresh,
  output logic                      glb_en
);
  localparam int BWORDS = (NUM_SRC + 31) / 32;
  localparam int PWORDS = (NUM_SRC + 3) / 4;

  logic              ns_q;
  logic [NUM_SRC-1:0] sec_q;
  logic [PRIO_W-1:0] prio_q [NUM_SRC];

  // address decode
  logic       aligned;
  logic [4:0] widx;
  logic [7:0] pidx;
  logic       ctrl_hit, thr_hit, sec_hit, set_hit, clr_hit, prio_hit, hip_hit, trig_hit;
  logic [ID_W-1:0] tid;

  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign widx     = bus_addr[6:2];
  assign pidx     = bus_addr[9:2];
  assign tid      = bus_wdata[ID_W-1:0];
  assign ctrl_hit = (bus_addr == OFF_CTRL);
  assign thr_hit  = (bus_addr == OFF_THRESH);
  assign trig_hit = (bus_addr == OFF_TRIG);
  assign sec_hit  = aligned && (bus_addr[11:7] == BASE_SEC[11:7])   && (int'(widx) < BWORDS);
  assign set_hit  = aligned && (bus_addr[11:7] == BASE_ENSET[11:7]) && (int'(widx) < BWORDS);
  assign clr_hit  = aligned && (bus_addr[11:7] == BASE_ENCLR[11:7]) && (int'(widx) < BWORDS);
  assign hip_hit  = aligned && (bus_addr[11:7] == BASE_HIP[11:7])   && (int'(widx) < BWORDS);
  assign prio_hit = aligned && (bus_addr[11:10] == BASE_PRIO[11:10]) && (int'(pidx) < PWORDS);

  always_ff @(posedge clk) begin
    if (rst) begin
      glb_en <= 1'b0;
      ns_q   <= 1'b0;
      thresh <= '0;
      sec_q  <= '0;
      en_vec <= '0;
      sw_vec <= '0;
      for (int i = 0; i < NUM_SRC; i++) prio_q[i] <= '0;
    end else if (bus_wr) begin
      if (ctrl_hit) begin
        glb_en <= bus_wdata[0];
        if (bus_wdata[31]) ns_q <= bus_wdata[16];
      end
      if (thr_hit) thresh <= bus_wdata[PRIO_W-1:0];
      for (int i = 0; i < NUM_SRC; i++) begin
        if (sec_hit && widx == 5'(i / 32)) sec_q[i] <= bus_wdata[i % 32];
        if (set_hit && widx == 5'(i / 32) && bus_wdata[i % 32]) en_vec[i] <= 1'b1;
        if (clr_hit && widx == 5'(i / 32) && bus_wdata[i % 32]) begin
          en_vec[i] <= 1'b0;
          sw_vec[i] <= 1'b0;
        end else if (trig_hit && tid == ID_W'(i)) begin
          sw_vec[i] <= 1'b1;
        end
        if (prio_hit && pidx == 8'(i / 4))
          prio_q[i] <= bus_wdata[(i % 4)*PRIO_W +: PRIO_W];
      end
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_prio_out
    assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q[g];
  end

  logic [DATA_W-1:0] rd_word;
  always_comb begin
    rd_word = '0;
    if (ctrl_hit) begin
      rd_word[0]  = glb_en;
      rd_word[16] = ns_q;
    end
    if (thr_hit) rd_word[PRIO_W-1:0] = thresh;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (widx == 5'(i / 32)) begin
        if (sec_hit)            rd_word[i % 32] = sec_q[i];
        if (set_hit || clr_hit) rd_word[i % 32] = en_vec[i];
        if (hip_hit)            rd_word[i % 32] = hip_vec[i];
      end
      if (prio_hit && pidx == 8'(i / 4))
        rd_word[(i % 4)*PRIO_W +: PRIO_W] = prio_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end
endmodule

// File: rtl/secirq_arb.sv
module secirq_arb
  import secirq_pkg::*;
#(
  parameter int NUM_SRC = 109,
  parameter int GRP     = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_SRC-1:0]        line_vec,
  input  logic [NUM_SRC-1:0]        sw_vec,
  input  logic [NUM_SRC-1:0]        en_vec,
  input  logic                      glb_en,
  input  logic [PRIO_W-1:0]         thresh,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  output logic [NUM_SRC-1:0]        hip_q,
  output logic                      irq_q
);
  localparam int NGRP = (NUM_SRC + GRP - 1) / GRP;

  logic [NUM_SRC-1:0]     elig;
  logic [NGRP*PRIO_W-1:0] gmax_flat;
  logic [PRIO_W-1:0]      top;
  logic [NUM_SRC-1:0]     hip_d;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
    assign elig[i] = (line_vec[i] | sw_vec[i]) & en_vec[i] & glb_en
                   & (prio_flat[i*PRIO_W +: PRIO_W] > thresh);
  end

  // first level: maximum inside each group of GRP sources
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int GCNT = (NUM_SRC - g*GRP < GRP) ? (NUM_SRC - g*GRP) : GRP;
    logic [PRIO_W-1:0] gm;
    always_comb begin
      gm = '0;
      for (int k = 0; k < GCNT; k++) begin
        if (elig[g*GRP + k] && prio_flat[(g*GRP + k)*PRIO_W +: PRIO_W] > gm)
          gm = prio_flat[(g*GRP + k)*PRIO_W +: PRIO_W];
      end
    end
    assign gmax_flat[g*PRIO_W +: PRIO_W] = gm;
  end

  // second level: maximum across groups
  always_comb begin
    top = '0;
    for (int g = 0; g < NGRP; g++)
      if (gmax_flat[g*PRIO_W +: PRIO_W] > top) top = gmax_flat[g*PRIO_W +: PRIO_W];
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_hip
    assign hip_d[i] = elig[i] && (prio_flat[i*PRIO_W +: PRIO_W] == top);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hip_q <= '0;
      irq_q <= 1'b0;
    end else begin
      hip_q <= hip_d;
      irq_q <= |elig;
    end
  end
endmodule

// File: rtl/secirq_ctrl.sv
module secirq_ctrl
  import secirq_pkg::*;
#(
  parameter int NUM_SRC = 109
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_lines,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_out
);
  logic [NUM_SRC-1:0]        en_vec;
  logic [NUM_SRC-1:0]        sw_vec;
  logic [NUM_SRC-1:0]        hip_vec;
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;
  logic [PRIO_W-1:0]         thresh;
  logic                      glb_en;

  secirq_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .hip_vec   (hip_vec),
    .en_vec    (en_vec),
    .sw_vec    (sw_vec),
    .prio_flat (prio_flat),
    .thresh    (thresh),
    .glb_en    (glb_en)
  );

  secirq_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .clk       (clk),
    .rst       (rst),
    .line_vec  (irq_lines),
    .sw_vec    (sw_vec),
    .en_vec    (en_vec),
    .glb_en    (glb_en),
    .thresh    (thresh),
    .prio_flat (prio_flat),
    .hip_q     (hip_vec),
    .irq_q     (irq_out)
  );
endmodule

// File: rtl/secirq_chk.sv
module secirq_chk
  import secirq_pkg::*;
#(
  parameter int NUM_SRC = 109
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [NUM_SRC-1:0] en_vec,
  input logic [NUM_SRC-1:0] sw_vec,
  input logic [NUM_SRC-1:0] hip_vec,
  input logic               glb_en,
  input logic               irq_out
);
  // R5: a write to the set bank never lowers an enable flag
  a_r5_set_only_raises: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr[11:7] == BASE_ENSET[11:7]) |=> (($past(en_vec) & ~en_vec) == '0));

  // R6: a write to the clear bank never raises an enable flag
  a_r6_clear_only_lowers: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr[11:7] == BASE_ENCLR[11:7]) |=> ((en_vec & ~$past(en_vec)) == '0));

  // R9: a bitmap bit needs the source enabled in the cycle before
  a_r9_hip_needs_enable: assert property (@(posedge clk) disable iff (rst)
    ((hip_vec & ~$past(en_vec)) == '0));

  // R10: the request output needs the global enable in the cycle before
  a_r10_irq_needs_glb: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(glb_en));

  // R10: request output agrees with the bitmap
  a_r10_irq_iff_hip: assert property (@(posedge clk) disable iff (rst)
    irq_out == (|hip_vec));

  // R11: out-of-range trigger numbers leave every latch unchanged
  a_r11_bad_id_ignored: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFF_TRIG && int'(bus_wdata[ID_W-1:0]) >= NUM_SRC)
      |=> (sw_vec == $past(sw_vec)));
endmodule

bind secirq_ctrl secirq_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .en_vec    (en_vec),
  .sw_vec    (sw_vec),
  .hip_vec   (hip_vec),
  .glb_en    (glb_en),
  .irq_out   (irq_out)
);

// File: tb/secirq_ctrl_tb.sv
module secirq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 109;
  localparam int WDOG = 20000;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSRC-1:0] irq_lines = '0;
  logic            bus_wr = 1'b0;
  logic            bus_rd = 1'b0;
  logic [11:0]     bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic            irq_out;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  secirq_ctrl #(.NUM_SRC(NSRC)) u_dut (
    .clk(clk), .rst(rst), .irq_lines(irq_lines), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t [0:NV-1] VECS = '{
    '{1'b0, 12'h000, 32'h0,          32'h0,          4'd1},  // R1 control clear
    '{1'b0, 12'hD80, 32'h0,          32'h0,          4'd1},  // R1 bitmap empty
    '{1'b1, 12'h000, 32'h0001_0001,  32'h0,          4'd2},  // R2 no guard bit
    '{1'b0, 12'h000, 32'h0,          32'h0000_0001,  4'd2},
    '{1'b1, 12'h000, 32'h8001_0001,  32'h0,          4'd2},  // R2 guarded write
    '{1'b0, 12'h000, 32'h0,          32'h0001_0001,  4'd2},
    '{1'b1, 12'h00C, 32'hFFFF_FF05,  32'h0,          4'd3},  // R3
    '{1'b0, 12'h00C, 32'h0,          32'h0000_0005,  4'd3},
    '{1'b1, 12'h08C, 32'hFFFF_FFFF,  32'h0,          4'd4},  // R4 last word
    '{1'b0, 12'h08C, 32'h0,          32'h0000_1FFF,  4'd4},
    '{1'b1, 12'h080, 32'hA5A5_0F0F,  32'h0,          4'd4},
    '{1'b0, 12'h080, 32'h0,          32'hA5A5_0F0F,  4'd4},
    '{1'b1, 12'h100, 32'h0000_00F0,  32'h0,          4'd5},  // R5 set
    '{1'b1, 12'h100, 32'h0000_0000,  32'h0,          4'd5},  // R5 zeros no effect
    '{1'b0, 12'h180, 32'h0,          32'h0000_00F0,  4'd5},
    '{1'b1, 12'h180, 32'h0000_0030,  32'h0,          4'd6},  // R6 clear
    '{1'b0, 12'h100, 32'h0,          32'h0000_00C0,  4'd6},
    '{1'b1, 12'h46C, 32'hAABB_CCDD,  32'h0,          4'd7},  // R7 partial word
    '{1'b0, 12'h46C, 32'h0,          32'h0000_00DD,  4'd7},
    '{1'b1, 12'h404, 32'h1122_3344,  32'h0,          4'd7},  // R7 sources 4..7
    '{1'b0, 12'h404, 32'h0,          32'h1122_3344,  4'd7},
    '{1'b0, 12'h200, 32'h0,          32'h0,          4'd12}, // R12 unmapped
    '{1'b0, 12'h090, 32'h0,          32'h0,          4'd12}  // R12 past last word
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic read_check(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_read(a, d);
    check(tag, d, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 irq_out after reset", {31'b0, irq_out}, 32'h0);

    for (int k = 0; k < NV; k++) begin
      if (VECS[k].wr) bus_write(VECS[k].addr, VECS[k].data);
      else read_check($sformatf("R%0d vector %0d", VECS[k].req, k), VECS[k].addr, VECS[k].exp);
    end

    // R8 R9: two lines, higher priority wins (src6=0x22, src7=0x11, threshold 5)
    irq_lines[6] = 1'b1; irq_lines[7] = 1'b1;
    idle(2);
    read_check("R9 highest only", 12'hD80, 32'h0000_0040);
    check("R10 irq high", {31'b0, irq_out}, 32'h1);

    // R9 ties: both 0x22
    bus_write(12'h404, 32'h2222_3344);
    idle(2);
    read_check("R9 ties", 12'hD80, 32'h0000_00C0);

    // R8 strict threshold
    bus_write(12'h00C, 32'h22);
    idle(2);
    read_check("R8 threshold equal", 12'hD80, 32'h0);
    check("R10 irq low at equal threshold", {31'b0, irq_out}, 32'h0);
    bus_write(12'h00C, 32'h21);
    idle(2);
    read_check("R8 threshold below", 12'hD80, 32'h0000_00C0);

    // R8 disabled source does not count, then wins once enabled (0x33)
    irq_lines[5] = 1'b1;
    idle(2);
    read_check("R8 disabled source", 12'hD80, 32'h0000_00C0);
    bus_write(12'h100, 32'h0000_0020);
    idle(2);
    read_check("R9 new winner", 12'hD80, 32'h0000_0020);

    // R8 global enable off
    bus_write(12'h000, 32'h0);
    idle(2);
    read_check("R8 global off", 12'hD80, 32'h0);
    check("R10 irq low global off", {31'b0, irq_out}, 32'h0);
    read_check("R2 ns bit kept", 12'h000, 32'h0001_0000);
    bus_write(12'h000, 32'h8000_0001);
    read_check("R2 ns bit cleared", 12'h000, 32'h0000_0001);

    // R10 one-cycle timing
    irq_lines = '0;
    idle(2);
    check("R10 irq idle", {31'b0, irq_out}, 32'h0);
    irq_lines[5] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R10 irq after one edge", {31'b0, irq_out}, 32'h1);
    irq_lines = '0;
    idle(2);

    // R11 software trigger of source 108 (word 3 bit 12, priority 0xDD)
    bus_write(12'h10C, 32'h0000_1000);
    bus_write(12'hF00, 32'd108);
    idle(2);
    read_check("R11 trigger", 12'hD8C, 32'h0000_1000);
    check("R11 irq on trigger", {31'b0, irq_out}, 32'h1);
    idle(5);
    read_check("R11 latch holds", 12'hD8C, 32'h0000_1000);
    bus_write(12'h18C, 32'h0000_1000);
    bus_write(12'h10C, 32'h0000_1000);
    idle(2);
    read_check("R11 latch cleared", 12'hD8C, 32'h0);
    bus_write(12'hF00, 32'd109);
    bus_write(12'hF00, 32'd1023);
    idle(2);
    read_check("R11 bad id ignored", 12'hD8C, 32'h0);
    check("R11 irq stays low", {31'b0, irq_out}, 32'h0);

    // R12 misaligned access
    bus_write(12'h00D, 32'hFF);
    read_check("R12 misaligned write ignored", 12'h00C, 32'h21);
    read_check("R12 misaligned read", 12'h00D, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule